// File: doc/BRIEF.md
# Serial-Bus DAC Register Slave

This block is a two-wire serial-bus slave that fronts a bank of eight 10-bit DAC code registers. It samples the bus clock and data lines with a much faster system clock and finds START, repeated START and STOP conditions. It answers a 7-bit device address whose lowest bit is set by a strap input. After the address, the master sends a channel pointer byte and then either writes or reads channel codes in pairs of bytes. The pointer moves to the next channel after every pair.

The register bank itself sits outside the block. A write reaches the bank as a one-cycle strobe that carries a channel index and a 10-bit code. A read takes its data from the bank through a combinational index/data pair. The block also gives single-cycle pulses for a software update, for a reset of one channel or all channels to midscale, and for a general-call full reset. A level output shows that the high-speed master code has been seen. SDA is driven as an open-drain pull-down enable.

Top module: `dacreg_i2c_slave`

## Requirements
- R1: The slave acknowledges a write or read address of 111010s, where s is the level of `addr_sel` (E8h/E9h with s=0, EAh/EBh with s=1). It does not acknowledge any other address, apart from the general call and high-speed cases below.
- R2: A pointer byte is acknowledged only if bits 4..3 are zero and bits 7..5 are 000, 100 or 010. Bits 2..0 become the channel pointer. Any other pointer byte is not acknowledged.
- R3: A channel code is written only on the second byte of a pair. The first byte supplies code bits 9..8 in its bits 1..0, and the second byte supplies bits 7..0. On that second byte, `wr_en` pulses for one cycle with `wr_idx` set to the channel and `wr_data` set to the code.
- R4: If a STOP or a repeated START arrives after the first byte of a pair, no write strobe is issued and the channel keeps its old code.
- R5: After every two data bytes, written or read, the pointer moves to the next channel.
- R6: Bit 7 of a written first byte (bit 15 of the 16-bit word) makes `upd_req` pulse in the same cycle as that channel's `wr_en`. When the bit is 0, there is no pulse.
- R7: General call address 00h is always acknowledged. A following data byte of 06h is acknowledged and pulses `gc_rst`. Any other general-call data byte is not acknowledged.
- R8: An address byte of 00001xxx is not acknowledged and sets `hs_mode`. `hs_mode` stays set through repeated STARTs and is cleared by the first STOP.
- R9: A pointer with bits 7..5 = 100 pulses `mid_all`. A pointer with bits 7..5 = 010 pulses `mid_one`, with `wr_idx` set to the pointed channel.
- R10: A read returns, for each channel, first a byte of 000000 followed by code bits 9..8, then a byte holding code bits 7..0, most significant bit first. A master not-acknowledge ends the read, and SDA is released.
- R11: Once the pointer has passed channel 7, further written bytes are not acknowledged and read bytes return FFh, with SDA left released.
- R12: `sda_oe` changes only while the bus clock is low.
- R13: After reset, `sda_oe`, `wr_en`, all pulse outputs and `hs_mode` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_sel | input | 1 | Strap that sets the device address LSB |
| sda_oe | output | 1 | Pull SDA low when high |
| rd_idx | output | 3 | Channel the read data is taken from |
| rd_data | input | 10 | Code of channel `rd_idx` from the bank |
| wr_en | output | 1 | One-cycle write strobe |
| wr_idx | output | 3 | Channel for the write or single-channel reset |
| wr_data | output | 10 | Code to write |
| upd_req | output | 1 | Software update pulse that comes with a write |
| mid_all | output | 1 | Pulse to set all channels to midscale |
| mid_one | output | 1 | Pulse to set channel `wr_idx` to midscale |
| gc_rst | output | 1 | General-call full reset pulse |
| hs_mode | output | 1 | High-speed master code seen since the last STOP |

## Verification
The hardest case to reach is the pointer running off the end of the bank. It needs a transaction that starts near channel 7 and keeps going past it, in both directions. The bench writes from channel 6 until the third pair's first byte is refused. It also reads from channel 6 through both channels into a fifth byte, which must come back as all ones. A partial pair cut off by a STOP, and another cut off by a repeated START, check that a write happens only on the second byte.

// File: rtl/dacreg_i2c_slave.sv
module dacreg_i2c_slave #(
  parameter logic [5:0] DEV_ID = 6'b111010,
  parameter int DATA_W = 10,
  parameter int IDX_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_sel,
  output logic              sda_oe,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_data,
  output logic              upd_req,
  output logic              mid_all,
  output logic              mid_one,
  output logic              gc_rst,
  output logic              hs_mode
);
  localparam int HI_W = DATA_W - 8;
  localparam logic [IDX_W-1:0] LAST = '1;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK} st_t;
  typedef enum logic [2:0] {B_ADDR, B_PTR, B_MSB, B_LSB, B_GC} role_t;

  logic [2:0] scl_sh, sda_sh;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sh <= 3'b111;
      sda_sh <= 3'b111;
    end else begin
      scl_sh <= {scl_sh[1:0], scl_i};
      sda_sh <= {sda_sh[1:0], sda_i};
    end

  wire scl_s = scl_sh[1], scl_q = scl_sh[2];
  wire sda_s = sda_sh[1], sda_q = sda_sh[2];
  wire start_c = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c  = scl_s & scl_q & ~sda_q & sda_s;
  wire rise    = scl_s & ~scl_q;
  wire fall    = ~scl_s & scl_q;

  st_t st;
  role_t role;
  logic [3:0] cnt;
  logic [7:0] sr, tx_byte;
  logic [IDX_W-1:0] ptr;
  logic ovf, rd_dir, lsb_next, hold_upd, mack;
  logic [HI_W-1:0] hold_hi;

  assign rd_idx = ptr;

  wire addr_hit = sr[7:1] == {DEV_ID, addr_sel};
  wire ptr_ok = (sr[4:3] == 2'b00) &&
                (sr[7:5] == 3'b000 || sr[7:5] == 3'b100 || sr[7:5] == 3'b010);
  wire tx_go = fall && ((st == S_ACK && rd_dir) || (st == S_MACK && mack));

  always_comb begin
    tx_byte = '0;
    if (ovf) tx_byte = '1;
    else if (lsb_next) tx_byte = rd_data[7:0];
    else tx_byte[HI_W-1:0] = rd_data[DATA_W-1:8];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; role <= B_ADDR; cnt <= '0; sr <= '0; ptr <= '0;
      ovf <= 1'b0; rd_dir <= 1'b0; lsb_next <= 1'b0; hold_upd <= 1'b0;
      hold_hi <= '0; mack <= 1'b0; sda_oe <= 1'b0; hs_mode <= 1'b0;
      wr_en <= 1'b0; wr_idx <= '0; wr_data <= '0; upd_req <= 1'b0;
      mid_all <= 1'b0; mid_one <= 1'b0; gc_rst <= 1'b0;
    end else begin
      wr_en <= 1'b0; upd_req <= 1'b0; mid_all <= 1'b0;
      mid_one <= 1'b0; gc_rst <= 1'b0;
      if (start_c) begin
        st <= S_RX; role <= B_ADDR; cnt <= '0; sda_oe <= 1'b0; rd_dir <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE; sda_oe <= 1'b0; hs_mode <= 1'b0;
      end else if (tx_go) begin
        st <= S_TX; sr <= tx_byte; cnt <= '0; sda_oe <= ~tx_byte[7];
        if (!ovf) begin
          if (lsb_next) begin
            lsb_next <= 1'b0;
            if (ptr == LAST) ovf <= 1'b1;
            else ptr <= ptr + IDX_W'(1);
          end else lsb_next <= 1'b1;
        end
      end else begin
        case (st)
          S_RX:
            if (rise && cnt < 4'd8) begin
              sr <= {sr[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (fall && cnt == 4'd8) begin
              st <= S_IDLE;
              case (role)
                B_ADDR:
                  if (addr_hit) begin
                    st <= S_ACK; sda_oe <= 1'b1; rd_dir <= sr[0];
                    role <= B_PTR; lsb_next <= 1'b0;
                  end else if (sr == 8'h00) begin
                    st <= S_ACK; sda_oe <= 1'b1; role <= B_GC;
                  end else if (sr[7:3] == 5'b00001) hs_mode <= 1'b1;
                B_PTR:
                  if (ptr_ok) begin
                    st <= S_ACK; sda_oe <= 1'b1; role <= B_MSB;
                    ptr <= sr[IDX_W-1:0]; ovf <= 1'b0; wr_idx <= sr[IDX_W-1:0];
                    mid_all <= sr[7]; mid_one <= sr[6];
                  end
                B_MSB:
                  if (!ovf) begin
                    st <= S_ACK; sda_oe <= 1'b1; role <= B_LSB;
                    hold_hi <= sr[HI_W-1:0]; hold_upd <= sr[7];
                  end
                B_LSB: begin
                  st <= S_ACK; sda_oe <= 1'b1; role <= B_MSB;
                  wr_en <= 1'b1; wr_idx <= ptr; wr_data <= {hold_hi, sr};
                  upd_req <= hold_upd;
                  if (ptr == LAST) ovf <= 1'b1;
                  else ptr <= ptr + IDX_W'(1);
                end
                B_GC:
                  if (sr == 8'h06) begin
                    st <= S_ACK; sda_oe <= 1'b1; gc_rst <= 1'b1;
                    ptr <= '0; ovf <= 1'b0;
                  end
                default: ;
              endcase
            end
          S_ACK:
            if (fall) begin
              sda_oe <= 1'b0; cnt <= '0; st <= S_RX;
            end
          S_TX:
            if (fall) begin
              if (cnt == 4'd7) begin
                sda_oe <= 1'b0; st <= S_MACK;
              end else begin
                sr <= {sr[6:0], 1'b0}; cnt <= cnt + 4'd1; sda_oe <= ~sr[6];
              end
            end
          S_MACK:
            if (rise) mack <= ~sda_s;
            else if (fall) st <= S_IDLE;
          default: ;
        endcase
      end
    end

  p_oe_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_s));
  p_commit_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  p_hs_no_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_mode) |-> !sda_oe);
  p_ovf_no_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && $past(ovf)) |-> !wr_en);
endmodule

// File: tb/sim_dacreg_i2c_slave.sv
module sim_dacreg_i2c_slave;
  localparam int Q = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1, addr_sel = 1'b0;
  logic sda_oe, wr_en, upd_req, mid_all, mid_one, gc_rst, hs_mode;
  logic [2:0] rd_idx, wr_idx;
  logic [9:0] rd_data, wr_data;
  wire sda_line = sda_m & ~sda_oe;
  logic [9:0] bank [8];
  int n_wr, n_upd, n_all, n_one, n_gc, n_oe_bad;
  int checks = 0, fails = 0;
  logic prev_oe;

  assign rd_data = bank[rd_idx];

  dacreg_i2c_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .addr_sel(addr_sel), .sda_oe(sda_oe), .rd_idx(rd_idx), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .upd_req(upd_req),
    .mid_all(mid_all), .mid_one(mid_one), .gc_rst(gc_rst), .hs_mode(hs_mode)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) bank[i] <= 10'd512;
      n_wr <= 0; n_upd <= 0; n_all <= 0; n_one <= 0; n_gc <= 0;
      n_oe_bad <= 0; prev_oe <= 1'b0;
    end else begin
      if (wr_en) bank[wr_idx] <= wr_data;
      if (mid_one) bank[wr_idx] <= 10'd512;
      if (mid_all || gc_rst) for (int i = 0; i < 8; i++) bank[i] <= 10'd512;
      n_wr <= n_wr + int'(wr_en);
      n_upd <= n_upd + int'(upd_req);
      n_all <= n_all + int'(mid_all);
      n_one <= n_one + int'(mid_one);
      n_gc <= n_gc + int'(gc_rst);
      prev_oe <= sda_oe;
      if (sda_oe !== prev_oe && scl_m) n_oe_bad <= n_oe_bad + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic i_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
    end
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); ack = !sda_line; q(); scl_m = 1'b0; q();
  endtask

  task automatic rbyte(input bit nak, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      scl_m = 1'b1; q(); b[i] = sda_line; q(); scl_m = 1'b0; q();
    end
    sda_m = nak; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; sda_m = 1'b1; q();
  endtask

  task automatic wr_pair(input string req, input logic [7:0] ptr_b,
                         input logic [7:0] hi, input logic [7:0] lo);
    bit a;
    i_start();
    wbyte(8'hE8, a); chk({req, " addr ack"}, int'(a), 1);
    wbyte(ptr_b, a); chk({req, " ptr ack"}, int'(a), 1);
    wbyte(hi, a);    chk({req, " msb ack"}, int'(a), 1);
    wbyte(lo, a);    chk({req, " lsb ack"}, int'(a), 1);
    i_stop();
  endtask

  task automatic t_reset();
    chk("R13 sda_oe", int'(sda_oe), 0);
    chk("R13 wr_en", int'(wr_en), 0);
    chk("R13 pulses", int'({upd_req, mid_all, mid_one, gc_rst}), 0);
    chk("R13 hs_mode", int'(hs_mode), 0);
  endtask

  task automatic t_addr();
    bit a;
    i_start(); wbyte(8'hEC, a); chk("R1 foreign address nak", int'(a), 0); i_stop();
    i_start(); wbyte(8'hE8, a); chk("R1 own address ack", int'(a), 1); i_stop();
    addr_sel = 1'b1; q();
    i_start(); wbyte(8'hE8, a); chk("R1 strap high rejects E8", int'(a), 0); i_stop();
    i_start(); wbyte(8'hEA, a); chk("R1 strap high accepts EA", int'(a), 1); i_stop();
    addr_sel = 1'b0; q();
  endtask

  task automatic t_write();
    int w0 = n_wr;
    wr_pair("R2 R3", 8'h02, 8'h02, 8'hA5);
    chk("R3 one strobe", n_wr - w0, 1);
    chk("R3 code", int'(bank[2]), 'h2A5);
  endtask

  task automatic t_multi();
    bit a;
    int w0 = n_wr;
    i_start(); wbyte(8'hE8, a); wbyte(8'h06, a);
    wbyte(8'h01, a); wbyte(8'h23, a);
    wbyte(8'h03, a); wbyte(8'hFF, a);
    chk("R5 second pair acked", int'(a), 1);
    wbyte(8'h00, a); chk("R11 past channel 7 nak", int'(a), 0);
    i_stop();
    chk("R5 two strobes", n_wr - w0, 2);
    chk("R5 ch6", int'(bank[6]), 'h123);
    chk("R5 ch7", int'(bank[7]), 'h3FF);
  endtask

  task automatic t_abort();
    bit a;
    int w0 = n_wr;
    i_start(); wbyte(8'hE8, a); wbyte(8'h03, a); wbyte(8'h02, a); i_stop();
    chk("R4 stop discards", n_wr - w0, 0);
    i_start(); wbyte(8'hE8, a); wbyte(8'h03, a); wbyte(8'h01, a);
    i_start(); wbyte(8'hE8, a); i_stop();
    chk("R4 restart discards", n_wr - w0, 0);
    chk("R4 ch3 unchanged", int'(bank[3]), 512);
  endtask

  task automatic t_upd();
    int u0c = n_upd;
    wr_pair("R6", 8'h04, 8'h81, 8'h11);
    chk("R6 update pulse", n_upd - u0c, 1);
    chk("R6 code", int'(bank[4]), 'h111);
    wr_pair("R6", 8'h04, 8'h01, 8'h22);
    chk("R6 no pulse when clear", n_upd - u0c, 1);
  endtask

  task automatic t_gc();
    bit a;
    int g0 = n_gc;
    i_start(); wbyte(8'h00, a); chk("R7 general call ack", int'(a), 1);
    wbyte(8'h06, a); chk("R7 reset byte ack", int'(a), 1); i_stop();
    chk("R7 reset pulse", n_gc - g0, 1);
    chk("R7 bank back to mid", int'(bank[2]), 512);
    i_start(); wbyte(8'h00, a); wbyte(8'h05, a);
    chk("R7 other byte nak", int'(a), 0); i_stop();
    chk("R7 no extra pulse", n_gc - g0, 1);
  endtask

  task automatic t_hs();
    bit a;
    i_start(); wbyte(8'h0D, a); chk("R8 master code nak", int'(a), 0);
    chk("R8 flag set", int'(hs_mode), 1);
    i_start(); wbyte(8'hE8, a); chk("R8 address after restart", int'(a), 1);
    chk("R8 flag kept", int'(hs_mode), 1);
    i_stop(); q();
    chk("R8 flag cleared", int'(hs_mode), 0);
  endtask

  task automatic t_mid();
    bit a;
    int o0 = n_one, m0 = n_all;
    wr_pair("R9 setup", 8'h01, 8'h01, 8'h55);
    wr_pair("R9 setup", 8'h05, 8'h00, 8'hAA);
    i_start(); wbyte(8'hE8, a); wbyte(8'h41, a);
    chk("R9 single reset ack", int'(a), 1); i_stop();
    chk("R9 single pulse", n_one - o0, 1);
    chk("R9 ch1 mid", int'(bank[1]), 512);
    chk("R9 ch5 kept", int'(bank[5]), 'h0AA);
    i_start(); wbyte(8'hE8, a); wbyte(8'h85, a); i_stop();
    chk("R9 all pulse", n_all - m0, 1);
    chk("R9 ch5 mid", int'(bank[5]), 512);
    i_start(); wbyte(8'hE8, a); wbyte(8'h08, a);
    chk("R2 padding bit nak", int'(a), 0); i_stop();
    i_start(); wbyte(8'hE8, a); wbyte(8'hC0, a);
    chk("R2 bad top bits nak", int'(a), 0); i_stop();
  endtask

  task automatic t_read();
    bit a;
    logic [7:0] b;
    i_start(); wbyte(8'hE8, a); wbyte(8'h06, a);
    wbyte(8'h02, a); wbyte(8'hC3, a); wbyte(8'h01, a); wbyte(8'h5A, a); i_stop();
    i_start(); wbyte(8'hE8, a); wbyte(8'h06, a);
    i_start(); wbyte(8'hE9, a); chk("R10 read address ack", int'(a), 1);
    rbyte(1'b0, b); chk("R10 ch6 high", int'(b), 'h02);
    rbyte(1'b0, b); chk("R10 ch6 low", int'(b), 'hC3);
    rbyte(1'b0, b); chk("R5 ch7 high", int'(b), 'h01);
    rbyte(1'b0, b); chk("R5 ch7 low", int'(b), 'h5A);
    rbyte(1'b1, b); chk("R11 past end reads ones", int'(b), 'hFF);
    chk("R10 released after nak", int'(sda_oe), 0);
    i_stop();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_addr();
    t_write();
    t_multi();
    t_abort();
    t_upd();
    t_gc();
    t_hs();
    t_mid();
    t_read();
    chk("R12 sda changes with clock low", n_oe_bad, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule